// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the software-visible face of a UART. It decodes a 32-bit, word-aligned register bus and holds the interrupt registers, the line and FIFO configuration, and the two data ports. The serial shifter, the FIFO storage and the baud generator live elsewhere. They send single-cycle event pulses and live FIFO flags and levels into this block. In return they receive configuration fields, push and pop strobes, and one-cycle FIFO flush pulses.

There are four interrupt sources. Each has a sticky state bit. A datapath event or a write to the test register sets the bit, and software clears it by writing 1. An interrupt line is high while both its state bit and its enable bit are set. The status word and the FIFO level word are not stored. Each read assembles them from the current datapath inputs, so they always show the FIFO's present condition.

A read returns data on `bus_rdata` at the clock edge that ends the access. The value then holds until the next read. The push and pop strobes are combinational with the bus access, so the FIFO updates at the same edge.

Top module: `uart_regfront`

## Requirements
- R1: Interrupt state is at byte offset 0x00. Bit 0 is TX watermark, bit 1 is RX watermark, bit 2 is TX empty and bit 3 is RX overflow. Writing it clears each bit written as 1. Writing the test register (offset 0x08) sets each bit written as 1.
- R2: Enable is at offset 0x04 and reads back its 4 bits. `irq[i]` is high exactly when state bit i and enable bit i are both 1.
- R3: A pulse on `ev_set[i]` sets state bit i at the next edge. If software clears the same bit in the same cycle, the set takes priority.
- R4: The test register reads as zero, and so does the write-data port.
- R5: Control is at offset 0x10 and reads back only its defined fields: TX enable (bit 0), RX enable (bit 1), system loopback (bit 4), line loopback (bit 5), parity enable (bit 6), odd parity (bit 7), break level (bits 9:8) and baud increment (bits 31:16). Each field drives its matching `cfg_*` output.
- R6: Status at offset 0x14 is built from the inputs: TX full (bit 0), RX full (bit 1), TX empty (bit 2), TX idle (bit 3), RX idle (bit 4), RX empty (bit 5). It reads 0x3C when the datapath is idle and empty. Writes to it are ignored.
- R7: FIFO control is at offset 0x20. The RX interrupt level sits in bits 4:2 and the TX interrupt level in bits 6:5; both drive `cfg_*` outputs. Writing 1 to bit 0 or bit 1 gives a one-cycle `rx_flush` or `tx_flush` pulse in the cycle after the write. Bits 1:0 read as zero.
- R8: FIFO status at offset 0x24 returns `tx_level` in bits 4:0 and `rx_level` in bits 20:16.
- R9: A write to offset 0x1C raises `tx_push` with `tx_byte` equal to the low data byte, unless `tx_full` is high. In that case no push occurs.
- R10: A read of offset 0x18 returns `rx_head` and raises `rx_pop` when `rx_empty` is low. When the FIFO is empty it returns zero and does not pop.
- R11: Offsets with no register (for example 0x0C, 0x28) read as zero. Writes to them, and to read-only offsets, change nothing.
- R12: After reset, all stored registers and outputs are zero, apart from status, which follows its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered at end of read |
| ev_set | input | 4 | Interrupt event pulses from datapath |
| irq | output | 4 | Level interrupt lines |
| tx_level | input | 5 | TX FIFO fill level |
| rx_level | input | 5 | RX FIFO fill level |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| tx_idle | input | 1 | Transmitter idle |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| rx_idle | input | 1 | Receiver idle |
| rx_head | input | 8 | Byte at RX FIFO head |
| tx_push | output | 1 | Push strobe into TX FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop strobe from RX FIFO |
| tx_flush | output | 1 | One-cycle TX FIFO reset |
| rx_flush | output | 1 | One-cycle RX FIFO reset |
| cfg_tx_en | output | 1 | TX enable |
| cfg_rx_en | output | 1 | RX enable |
| cfg_sys_lpbk | output | 1 | System loopback |
| cfg_line_lpbk | output | 1 | Line loopback |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_odd | output | 1 | Odd parity select |
| cfg_brk_lvl | output | 2 | RX break detect level |
| cfg_nco | output | 16 | Baud increment |
| cfg_rx_ilvl | output | 3 | RX interrupt level |
| cfg_tx_ilvl | output | 2 | TX interrupt level |

## Verification
The pop assertion expects `rx_head` to stay constant through the read cycle. It does not model a FIFO that changes its head during that cycle. The interrupt assertions expect `ev_set` to be low while reset is active. The bench meets both conditions:
- It drives every bus access, event pulse and FIFO-flag change on the falling edge and holds it for a whole cycle.
- It changes `rx_head` only between accesses.
- It keeps `ev_set` at zero except for the directed pulses.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_IRQ = 4;
    localparam int LVL_W   = 5;

    // Interrupt bit positions
    localparam int IRQ_TXWM  = 0;
    localparam int IRQ_RXWM  = 1;
    localparam int IRQ_TXEMP = 2;
    localparam int IRQ_RXOVF = 3;

    // Byte offsets
    localparam logic [7:0] OFS_ISTATE = 8'h00;
    localparam logic [7:0] OFS_IEN    = 8'h04;
    localparam logic [7:0] OFS_ITEST  = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_STAT   = 8'h14;
    localparam logic [7:0] OFS_RDAT   = 8'h18;
    localparam logic [7:0] OFS_WDAT   = 8'h1C;
    localparam logic [7:0] OFS_FCTRL  = 8'h20;
    localparam logic [7:0] OFS_FSTAT  = 8'h24;

    typedef enum logic [3:0] {
        REG_ISTATE, REG_IEN, REG_ITEST, REG_CTRL, REG_STAT,
        REG_RDAT, REG_WDAT, REG_FCTRL, REG_FSTAT, REG_NONE
    } reg_id_e;

    typedef struct packed {
        logic [15:0] nco;
        logic [1:0]  brk_lvl;
        logic        par_odd;
        logic        par_en;
        logic        line_lpbk;
        logic        sys_lpbk;
        logic        rx_en;
        logic        tx_en;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] rx_ilvl;
        logic [1:0] tx_ilvl;
    } fctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.nco       = w[31:16];
        c.brk_lvl   = w[9:8];
        c.par_odd   = w[7];
        c.par_en    = w[6];
        c.line_lpbk = w[5];
        c.sys_lpbk  = w[4];
        c.rx_en     = w[1];
        c.tx_en     = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        return {c.nco, 6'b0, c.brk_lvl, c.par_odd, c.par_en,
                c.line_lpbk, c.sys_lpbk, 2'b0, c.rx_en, c.tx_en};
    endfunction

    function automatic fctrl_t fctrl_from_word(logic [DATA_W-1:0] w);
        fctrl_t f;
        f.rx_ilvl = w[4:2];
        f.tx_ilvl = w[6:5];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] fctrl_to_word(fctrl_t f);
        return {25'b0, f.tx_ilvl, f.rx_ilvl, 2'b00};
    endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_id_e           reg_id,
    output logic              wr_en,
    output logic              rd_en
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] word_addr;

    assign word_addr = bus_addr & WORD_MASK;
    assign wr_en     = bus_valid &  bus_write;
    assign rd_en     = bus_valid & ~bus_write;

    always_comb begin
        case (word_addr)
            ADDR_W'(OFS_ISTATE): reg_id = REG_ISTATE;
            ADDR_W'(OFS_IEN):    reg_id = REG_IEN;
            ADDR_W'(OFS_ITEST):  reg_id = REG_ITEST;
            ADDR_W'(OFS_CTRL):   reg_id = REG_CTRL;
            ADDR_W'(OFS_STAT):   reg_id = REG_STAT;
            ADDR_W'(OFS_RDAT):   reg_id = REG_RDAT;
            ADDR_W'(OFS_WDAT):   reg_id = REG_WDAT;
            ADDR_W'(OFS_FCTRL):  reg_id = REG_FCTRL;
            ADDR_W'(OFS_FSTAT):  reg_id = REG_FSTAT;
            default:             reg_id = REG_NONE;
        endcase
    end

endmodule

// File: rtl/uart_rf_intr.sv
module uart_rf_intr
    import uart_rf_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_state,
    input  logic         wr_enable,
    input  logic         wr_test,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] ev_set,
    output logic [N-1:0] state_q,
    output logic [N-1:0] enable_q,
    output logic [N-1:0] irq
);

    always_ff @(posedge clk) begin
        if (rst)            enable_q <= '0;
        else if (wr_enable) enable_q <= wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic clr_i, set_i;
        assign clr_i = wr_state & wdata[i];
        assign set_i = ev_set[i] | (wr_test & wdata[i]);

        // set has priority over a same-cycle clear
        always_ff @(posedge clk) begin
            if (rst)        state_q[i] <= 1'b0;
            else if (set_i) state_q[i] <= 1'b1;
            else if (clr_i) state_q[i] <= 1'b0;
        end

        assign irq[i] = state_q[i] & enable_q[i];

        assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
            ev_set[i] |=> state_q[i]);
        assert_test_sets_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_test && wdata[i]) |=> state_q[i]);
        assert_w1c_clears_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_state && wdata[i] && !ev_set[i]) |=> !state_q[i]);
        assert_bit_holds_R1: assert property (@(posedge clk) disable iff (rst)
            (!wr_state && !wr_test && !ev_set[i]) |=> $stable(state_q[i]));
    end

endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
    import uart_rf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_ctrl,
    input  ctrl_t  ctrl_new,
    input  logic   wr_fctrl,
    input  fctrl_t fctrl_new,
    input  logic   rx_rst_req,
    input  logic   tx_rst_req,
    output ctrl_t  ctrl_q,
    output fctrl_t fctrl_q,
    output logic   rx_flush,
    output logic   tx_flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            fctrl_q  <= '0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= ctrl_new;
            if (wr_fctrl) fctrl_q <= fctrl_new;
            rx_flush <= wr_fctrl & rx_rst_req;
            tx_flush <= wr_fctrl & tx_rst_req;
        end
    end

    assert_rx_flush_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_fctrl && rx_rst_req) |=> rx_flush);
    assert_rx_flush_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_fctrl && rx_rst_req) |=> !rx_flush);
    assert_tx_flush_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_fctrl && tx_rst_req) |=> tx_flush);
    assert_ctrl_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        ev_set,
    output logic [3:0]        irq,
    input  logic [4:0]        tx_level,
    input  logic [4:0]        rx_level,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              tx_idle,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              rx_idle,
    input  logic [7:0]        rx_head,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    output logic              rx_pop,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              cfg_tx_en,
    output logic              cfg_rx_en,
    output logic              cfg_sys_lpbk,
    output logic              cfg_line_lpbk,
    output logic              cfg_par_en,
    output logic              cfg_par_odd,
    output logic [1:0]        cfg_brk_lvl,
    output logic [15:0]       cfg_nco,
    output logic [2:0]        cfg_rx_ilvl,
    output logic [1:0]        cfg_tx_ilvl
);

    reg_id_e              reg_id;
    logic                 wr_en, rd_en;
    logic [NUM_IRQ-1:0]   istate, ienable;
    ctrl_t                ctrl_q;
    fctrl_t               fctrl_q;
    logic [DATA_W-1:0]    rd_mux;

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .reg_id    (reg_id),
        .wr_en     (wr_en),
        .rd_en     (rd_en)
    );

    uart_rf_intr #(.N(NUM_IRQ)) u_intr (
        .clk       (clk),
        .rst       (rst),
        .wr_state  (wr_en && reg_id == REG_ISTATE),
        .wr_enable (wr_en && reg_id == REG_IEN),
        .wr_test   (wr_en && reg_id == REG_ITEST),
        .wdata     (bus_wdata[NUM_IRQ-1:0]),
        .ev_set    (ev_set),
        .state_q   (istate),
        .enable_q  (ienable),
        .irq       (irq)
    );

    uart_rf_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_en && reg_id == REG_CTRL),
        .ctrl_new   (ctrl_from_word(bus_wdata)),
        .wr_fctrl   (wr_en && reg_id == REG_FCTRL),
        .fctrl_new  (fctrl_from_word(bus_wdata)),
        .rx_rst_req (bus_wdata[0]),
        .tx_rst_req (bus_wdata[1]),
        .ctrl_q     (ctrl_q),
        .fctrl_q    (fctrl_q),
        .rx_flush   (rx_flush),
        .tx_flush   (tx_flush)
    );

    // FIFO strobes, combinational with the bus access
    assign tx_push = wr_en && reg_id == REG_WDAT && !tx_full;
    assign tx_byte = bus_wdata[7:0];
    assign rx_pop  = rd_en && reg_id == REG_RDAT && !rx_empty;

    always_comb begin
        case (reg_id)
            REG_ISTATE: rd_mux = DATA_W'(istate);
            REG_IEN:    rd_mux = DATA_W'(ienable);
            REG_CTRL:   rd_mux = ctrl_to_word(ctrl_q);
            REG_STAT:   rd_mux = {26'b0, rx_empty, rx_idle, tx_idle,
                                  tx_empty, rx_full, tx_full};
            REG_RDAT:   rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
            REG_FCTRL:  rd_mux = fctrl_to_word(fctrl_q);
            REG_FSTAT:  rd_mux = {11'b0, rx_level, 11'b0, tx_level};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    assign cfg_tx_en     = ctrl_q.tx_en;
    assign cfg_rx_en     = ctrl_q.rx_en;
    assign cfg_sys_lpbk  = ctrl_q.sys_lpbk;
    assign cfg_line_lpbk = ctrl_q.line_lpbk;
    assign cfg_par_en    = ctrl_q.par_en;
    assign cfg_par_odd   = ctrl_q.par_odd;
    assign cfg_brk_lvl   = ctrl_q.brk_lvl;
    assign cfg_nco       = ctrl_q.nco;
    assign cfg_rx_ilvl   = fctrl_q.rx_ilvl;
    assign cfg_tx_ilvl   = fctrl_q.tx_ilvl;

    assert_pop_returns_head_R10: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> bus_rdata == DATA_W'($past(rx_head)));
    assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_full && bus_valid) |-> !tx_push);
    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0]  ev_set, irq;
    logic [4:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, tx_idle, rx_full, rx_empty, rx_idle;
    logic [7:0]  rx_head, tx_byte;
    logic        tx_push, rx_pop, tx_flush, rx_flush;
    logic        cfg_tx_en, cfg_rx_en, cfg_sys_lpbk, cfg_line_lpbk;
    logic        cfg_par_en, cfg_par_odd;
    logic [1:0]  cfg_brk_lvl, cfg_tx_ilvl;
    logic [15:0] cfg_nco;
    logic [2:0]  cfg_rx_ilvl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    uart_regfront u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_set(ev_set), .irq(irq), .tx_level(tx_level), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_idle(tx_idle),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_idle(rx_idle),
        .rx_head(rx_head), .tx_push(tx_push), .tx_byte(tx_byte),
        .rx_pop(rx_pop), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_sys_lpbk(cfg_sys_lpbk), .cfg_line_lpbk(cfg_line_lpbk),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_brk_lvl(cfg_brk_lvl), .cfg_nco(cfg_nco),
        .cfg_rx_ilvl(cfg_rx_ilvl), .cfg_tx_ilvl(cfg_tx_ilvl)
    );

    // {is_write, addr, wdata, expected read}
    localparam int NV = 24;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h10, 32'h0, 32'h0000_0000},   // R12 ctrl reset
        {1'b0, 8'h00, 32'h0, 32'h0000_0000},   // R12 state reset
        {1'b0, 8'h20, 32'h0, 32'h0000_0000},   // R12 fifo ctrl reset
        {1'b0, 8'h14, 32'h0, 32'h0000_003C},   // R6 idle status
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h10, 32'h0, 32'hFFFF_03F3},   // R5 defined fields only
        {1'b1, 8'h10, 32'h1234_0251, 32'h0},
        {1'b0, 8'h10, 32'h0, 32'h1234_0251},   // R5
        {1'b1, 8'h14, 32'h0000_0000, 32'h0},
        {1'b0, 8'h14, 32'h0, 32'h0000_003C},   // R6 write ignored
        {1'b1, 8'h20, 32'h0000_007C, 32'h0},
        {1'b0, 8'h20, 32'h0, 32'h0000_007C},   // R7
        {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h04, 32'h0, 32'h0000_000F},   // R2
        {1'b1, 8'h08, 32'h0000_0005, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_0000},   // R4 test reads zero
        {1'b0, 8'h00, 32'h0, 32'h0000_0005},   // R1 test sets
        {1'b1, 8'h00, 32'h0000_0001, 32'h0},
        {1'b0, 8'h00, 32'h0, 32'h0000_0004},   // R1 w1c
        {1'b0, 8'h0C, 32'h0, 32'h0000_0000},   // R11 unmapped
        {1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h10, 32'h0, 32'h1234_0251},   // R11 no side effect
        {1'b0, 8'h1C, 32'h0, 32'h0000_0000},   // R4 write port reads zero
        {1'b0, 8'h24, 32'h0, 32'h0000_0000}    // R8 empty levels
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        ev_set = 0; tx_level = 0; rx_level = 0; tx_full = 0; rx_full = 0;
        tx_empty = 1; tx_idle = 1; rx_empty = 1; rx_idle = 1; rx_head = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 irq", 32'(irq), 32'h0);
        chk("R12 flush", {30'b0, tx_flush, rx_flush}, 32'h0);
        chk("R12 cfg nco", 32'(cfg_nco), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                bus_wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                bus_rd(VEC[i][71:64], rd);
                chk($sformatf("vec%0d", i), rd, VEC[i][31:0]);
            end
        end

        // R5 field outputs for 0x12340251
        chk("R5 cfg fields",
            {cfg_nco, 8'b0, cfg_brk_lvl, cfg_par_odd, cfg_par_en,
             cfg_line_lpbk, cfg_sys_lpbk, cfg_rx_en, cfg_tx_en},
            {16'h1234, 8'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1});
        chk("R7 ilvl outputs", {27'b0, cfg_rx_ilvl, cfg_tx_ilvl}, {27'b0, 3'b111, 2'b11});

        // R2 irq = state & enable (state = 0x4, enable = 0xF)
        chk("R2 irq enabled", 32'(irq), 32'h4);
        bus_wr(8'h04, 32'h0000_000B);
        chk("R2 irq masked", 32'(irq), 32'h0);
        bus_rd(8'h00, rd);
        chk("R2 state kept when masked", rd, 32'h4);

        // R3 event sets, and wins over same-cycle clear
        bus_wr(8'h00, 32'hF);
        @(negedge clk); ev_set = 4'b0010;
        @(negedge clk); ev_set = 4'b0000;
        bus_rd(8'h00, rd);
        chk("R3 event set", rd, 32'h2);
        chk("R3 irq from event", 32'(irq), 32'h2);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h00; bus_wdata = 32'h8;
        ev_set = 4'b1000;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; ev_set = 0;
        bus_rd(8'h00, rd);
        chk("R3 set beats clear", rd, 32'hA);

        // R6 live status, R8 live levels
        tx_full = 1; rx_full = 1; tx_empty = 0; tx_idle = 0; rx_empty = 0; rx_idle = 0;
        bus_rd(8'h14, rd);
        chk("R6 live status", rd, 32'h0000_0003);
        tx_level = 5'd17; rx_level = 5'd9;
        bus_rd(8'h24, rd);
        chk("R8 levels", rd, 32'h0009_0011);

        // R9 push / blocked push
        tx_full = 0;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h1C; bus_wdata = 32'hABCD_EF5A;
        #2;
        chk("R9 push", {23'b0, tx_push, tx_byte}, {23'b0, 1'b1, 8'h5A});
        tx_full = 1;
        #1;
        chk("R9 full blocks push", 32'(tx_push), 32'h0);
        @(negedge clk);
        bus_valid = 0; bus_write = 0; tx_full = 0;

        // R10 pop and empty read
        rx_empty = 0; rx_head = 8'hC3;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h18;
        #2;
        chk("R10 pop strobe", 32'(rx_pop), 32'h1);
        @(negedge clk);
        bus_valid = 0;
        chk("R10 head data", bus_rdata, 32'h0000_00C3);
        rx_empty = 1; rx_head = 8'h77;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h18;
        #2;
        chk("R10 no pop when empty", 32'(rx_pop), 32'h0);
        @(negedge clk);
        bus_valid = 0;
        chk("R10 empty reads zero", bus_rdata, 32'h0);

        // R7 flush pulses
        bus_wr(8'h20, 32'h0000_0003);
        chk("R7 flush pulse", {30'b0, tx_flush, rx_flush}, 32'h3);
        @(negedge clk);
        chk("R7 flush one cycle", {30'b0, tx_flush, rx_flush}, 32'h0);
        bus_rd(8'h20, rd);
        chk("R7 reset bits read zero", rd, 32'h0);
        bus_wr(8'h20, 32'h0000_0001);
        chk("R7 rx flush only", {30'b0, tx_flush, rx_flush}, 32'h1);

        // R11 write to read-only data port does not pop
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h18; bus_wdata = 32'hFF;
        rx_empty = 0;
        #2;
        chk("R11 write to read port", 32'(rx_pop), 32'h0);
        @(negedge clk);
        bus_valid = 0; bus_write = 0; rx_empty = 1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule